// File: doc/BRIEF.md
# Indexed Colour Palette Loader

This block holds the colour lookup table of an indexed-colour framebuffer: 2^IDX_W entries, each a red, a green and a blue component. A host loads it through two bus registers. Writing the pointer register picks an entry and returns the loader to its red slot. Writing the colour data register then stores components one at a time, red, green and blue, into the entry the pointer selects. After the blue component the pointer moves on to the next entry, so a whole palette can be streamed through one register once the pointer is set.

A data write can be one byte or a full bus word. A word write is split into its bytes, which are handled one after another with the most significant byte first. It therefore often ends part way through an entry or spills into the next one. Every data write raises a sticky redraw request for the display side. A combinational lookup port gives the pixel path the packed colour of any entry.

Top module: `clut_loader`

## Requirements
- R1: A write to offset 0x0 loads the pointer from bus_wdata[7:0] and sets the next component slot to red, whatever slot was pending before.
- R2: A byte write (bus_wide=0) to offset 0x4 stores bus_wdata[7:0] into the red, green or blue component of the entry under the pointer. Successive byte writes fill the components in that order.
- R3: Storing a blue component advances the pointer by one, modulo 256 (255 wraps to 0), and returns the slot to red.
- R4: A word write (bus_wide=1) to offset 0x4 has the same effect as four byte writes of bus_wdata[31:24], [23:16], [15:8] and [7:0], in that order. This holds across entry boundaries, and the whole word is stored in the one cycle it is presented.
- R5: A read (bus_write=0) at offset 0x0 or 0x4 returns zero on bus_rdata and changes neither the pointer nor the slot.
- R6: Reset clears every component of every entry to zero, sets the pointer to 0 and the slot to red, and raises redraw_req.
- R7: Every data write sets redraw_req on the next clock edge. A redraw_clr pulse clears it. When a data write and redraw_clr fall in the same cycle, the set wins.
- R8: lut_color is {red, green, blue} of the entry selected by lut_index, with red in bits 23:16. It follows lut_index without a clock.
- R9: A write to any offset other than 0x0 and 0x4, or bus activity with bus_valid low, changes neither the table, the pointer nor the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Register byte offset |
| bus_wide | input | 1 | 1 for a 32-bit data write, 0 for a single byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| redraw_clr | input | 1 | Clears the redraw request |
| redraw_req | output | 1 | Sticky request for a full-frame redraw |
| lut_index | input | 8 | Lookup entry for the pixel path |
| lut_color | output | 24 | Lookup result {red, green, blue} |

## Verification
A write is captured at the rising edge where bus_valid and bus_write are high. The table, the pointer, the slot and redraw_req all take the new values at that same edge. The bench changes its inputs 2 ns after a rising edge and checks redraw_req only after the capturing edge has passed. Lookups are combinational, so the driver sets lut_index in the cycle after the last write and pushes the colour it expects, and the monitor takes that colour from the queue at the falling edge of the same cycle. Read data is compared within the cycle in which the read is presented.

// File: rtl/clut_pkg.sv
package clut_pkg;

   localparam int NUM_TBL = 3;

   typedef enum logic [1:0] {
      SLOT_RED = 2'd0,
      SLOT_GRN = 2'd1,
      SLOT_BLU = 2'd2
   } slot_e;

   function automatic logic [1:0] slot_step(input logic [1:0] s);
      return (s == SLOT_BLU) ? SLOT_RED : s + 2'd1;
   endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int COMP_W  = 8,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 5,
   parameter int IDX_OFS = 0,
   parameter int MAP_OFS = 4,
   localparam int LANES  = BUS_W / COMP_W
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_valid,
   input  logic                           bus_write,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_wide,
   input  logic [BUS_W-1:0]               bus_wdata,
   output logic                           map_wr,
   output logic [LANES-1:0]               lane_en,
   output logic [LANES-1:0][1:0]          lane_tbl,
   output logic [LANES-1:0][IDX_W-1:0]    lane_idx,
   output logic [LANES-1:0][COMP_W-1:0]   lane_dat
);

   logic             idx_wr;
   logic [IDX_W-1:0] cur_idx;
   logic [1:0]       cur_ph;
   logic [1:0]       ph_c  [0:LANES];
   logic [IDX_W-1:0] idx_c [0:LANES];

   assign idx_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(IDX_OFS));
   assign map_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(MAP_OFS));

   assign ph_c[0]  = cur_ph;
   assign idx_c[0] = cur_idx;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_tbl[k]  = ph_c[k];
      assign lane_idx[k]  = idx_c[k];
      assign ph_c[k+1]    = slot_step(ph_c[k]);
      assign idx_c[k+1]   = idx_c[k] + ((ph_c[k] == SLOT_BLU) ? IDX_W'(1) : IDX_W'(0));
      if (k == 0) begin : g_first
         assign lane_en[k]  = map_wr;
         assign lane_dat[k] = bus_wide ? bus_wdata[BUS_W-1 -: COMP_W]
                                       : bus_wdata[COMP_W-1:0];
      end else begin : g_rest
         assign lane_en[k]  = map_wr && bus_wide;
         assign lane_dat[k] = bus_wdata[BUS_W-1-k*COMP_W -: COMP_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx <= '0;
         cur_ph  <= SLOT_RED;
      end else if (idx_wr) begin
         cur_idx <= bus_wdata[IDX_W-1:0];
         cur_ph  <= SLOT_RED;
      end else if (map_wr) begin
         if (bus_wide) begin
            cur_idx <= idx_c[LANES];
            cur_ph  <= ph_c[LANES];
         end else begin
            cur_idx <= idx_c[1];
            cur_ph  <= ph_c[1];
         end
      end
   end

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
   parameter int        IDX_W  = 8,
   parameter int        COMP_W = 8,
   parameter int        LANES  = 4,
   parameter logic [1:0] TBL   = 2'd0,
   localparam int       DEPTH  = 1 << IDX_W
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LANES-1:0]              lane_en,
   input  logic [LANES-1:0][1:0]         lane_tbl,
   input  logic [LANES-1:0][IDX_W-1:0]   lane_idx,
   input  logic [LANES-1:0][COMP_W-1:0]  lane_dat,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [COMP_W-1:0]             rd_dat
);

   logic [COMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else begin
         for (int k = 0; k < LANES; k++) begin
            if (lane_en[k] && lane_tbl[k] == TBL) mem[lane_idx[k]] <= lane_dat[k];
         end
      end
   end

   assign rd_dat = mem[rd_idx];

endmodule

// File: rtl/clut_redraw.sv
module clut_redraw (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b1;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
   import clut_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int COMP_W  = 8,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 5,
   parameter int IDX_OFS = 0,
   parameter int MAP_OFS = 4,
   localparam int LANES  = BUS_W / COMP_W
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_valid,
   input  logic                       bus_write,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wide,
   input  logic [BUS_W-1:0]           bus_wdata,
   output logic [BUS_W-1:0]           bus_rdata,
   input  logic                       redraw_clr,
   output logic                       redraw_req,
   input  logic [IDX_W-1:0]           lut_index,
   output logic [NUM_TBL*COMP_W-1:0]  lut_color
);

   if (BUS_W % COMP_W != 0 || LANES < 1) begin : g_bad_lanes
      $error("BUS_W must be a whole multiple of COMP_W");
   end
   if (IDX_W > BUS_W) begin : g_bad_idx
      $error("IDX_W must fit in the bus word");
   end
   if (IDX_OFS == MAP_OFS || IDX_OFS >= (1 << ADDR_W) || MAP_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("register offsets must differ and fit in ADDR_W");
   end

   logic                         map_wr;
   logic [LANES-1:0]             lane_en;
   logic [LANES-1:0][1:0]        lane_tbl;
   logic [LANES-1:0][IDX_W-1:0]  lane_idx;
   logic [LANES-1:0][COMP_W-1:0] lane_dat;
   logic [COMP_W-1:0]            comp [NUM_TBL];

   clut_seq #(
      .IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W),
      .ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wide(bus_wide), .bus_wdata(bus_wdata),
      .map_wr(map_wr), .lane_en(lane_en), .lane_tbl(lane_tbl),
      .lane_idx(lane_idx), .lane_dat(lane_dat)
   );

   for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      clut_bank #(
         .IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES), .TBL(2'(t))
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .lane_en(lane_en), .lane_tbl(lane_tbl), .lane_idx(lane_idx),
         .lane_dat(lane_dat), .rd_idx(lut_index), .rd_dat(comp[t])
      );
      assign lut_color[(NUM_TBL-t)*COMP_W-1 -: COMP_W] = comp[t];
   end

   clut_redraw u_redraw (
      .clk(clk), .rst_n(rst_n),
      .set_i(map_wr), .clr_i(redraw_clr), .flag_o(redraw_req)
   );

   assign bus_rdata = '0;

endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
   parameter int IDX_W   = 8,
   parameter int COMP_W  = 8,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 5,
   parameter int IDX_OFS = 0,
   parameter int MAP_OFS = 4
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_valid,
   input logic                  bus_write,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_wide,
   input logic [BUS_W-1:0]      bus_wdata,
   input logic                  redraw_clr,
   input logic                  redraw_req,
   input logic [IDX_W-1:0]      lut_index,
   input logic [3*COMP_W-1:0]   lut_color,
   input logic [IDX_W-1:0]      cur_idx,
   input logic [1:0]            cur_ph
);

   logic idx_wr, map_wr, other_wr;
   assign idx_wr   = bus_valid && bus_write && bus_addr == ADDR_W'(IDX_OFS);
   assign map_wr   = bus_valid && bus_write && bus_addr == ADDR_W'(MAP_OFS);
   assign other_wr = bus_valid && bus_write && !idx_wr && !map_wr;

   // pointer advance of a four-byte word, from the slot it starts in
   function automatic logic [IDX_W-1:0] word_adv(input logic [1:0] s);
      return (s == 2'd2) ? IDX_W'(2) : IDX_W'(1);
   endfunction

   a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (cur_idx == $past(bus_wdata[IDX_W-1:0]) && cur_ph == 2'd0));

   a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr && !bus_wide && cur_ph != 2'd2) |=>
         (cur_ph == $past(cur_ph) + 2'd1 && $stable(cur_idx)));

   a_r3_wrap_after_blue: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr && !bus_wide && cur_ph == 2'd2) |=>
         (cur_ph == 2'd0 && cur_idx == $past(cur_idx) + IDX_W'(1)));

   a_r4_word_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr && bus_wide) |=>
         (cur_ph == (($past(cur_ph) == 2'd2) ? 2'd0 : $past(cur_ph) + 2'd1) &&
          cur_idx == $past(cur_idx) + word_adv($past(cur_ph))));

   a_r5_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> ($stable(cur_idx) && $stable(cur_ph)));

   a_r7_redraw_set: assert property (@(posedge clk) disable iff (!rst_n)
      map_wr |=> redraw_req);

   a_r7_redraw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (redraw_clr && !map_wr) |=> !redraw_req);

   a_r8_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(lut_index) && !$past(map_wr)) |-> $stable(lut_color));

   a_r9_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (other_wr || !bus_valid) |=> ($stable(cur_idx) && $stable(cur_ph)));

endmodule

bind clut_loader clut_loader_chk #(
   .IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W),
   .ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
   .bus_wide(bus_wide), .bus_wdata(bus_wdata),
   .redraw_clr(redraw_clr), .redraw_req(redraw_req),
   .lut_index(lut_index), .lut_color(lut_color),
   .cur_idx(u_seq.cur_idx), .cur_ph(u_seq.cur_ph)
);

// File: tb/clut_loader_test.sv
module clut_loader_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_valid, bus_write, bus_wide, redraw_clr;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        redraw_req;
   logic [7:0]  lut_index;
   logic [23:0] lut_color;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mr [256];
   logic [7:0] mg [256];
   logic [7:0] mb [256];
   logic [7:0] midx;
   int         mph;

   logic [23:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   clut_loader uut (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .redraw_clr(redraw_clr), .redraw_req(redraw_req),
      .lut_index(lut_index), .lut_color(lut_color)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares the lookup pushed earlier in this cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [23:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(lut_color === e, t, {8'h0, lut_color}, {8'h0, e});
      end
   end

   task automatic model_byte(input logic [7:0] b);
      case (mph)
         0: mr[midx] = b;
         1: mg[midx] = b;
         default: mb[midx] = b;
      endcase
      if (mph == 2) midx = midx + 8'd1;
      mph = (mph + 1) % 3;
   endtask

   task automatic model_reset();
      for (int i = 0; i < 256; i++) begin
         mr[i] = '0; mg[i] = '0; mb[i] = '0;
      end
      midx = '0;
      mph = 0;
   endtask

   task automatic bus_wr(input logic [4:0] a, input bit wide, input logic [31:0] d,
                         input bit clr = 1'b0);
      @(posedge clk); #2;
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wide = wide;
      bus_wdata = d; redraw_clr = clr;
      @(posedge clk); #2;
      bus_valid = 1'b0; bus_write = 1'b0; redraw_clr = 1'b0;
      bus_wdata = 32'hDEAD_BEEF;
      if (a == 5'h0) begin
         midx = d[7:0];
         mph = 0;
      end else if (a == 5'h4) begin
         if (wide) for (int k = 3; k >= 0; k--) model_byte(d[8*k +: 8]);
         else model_byte(d[7:0]);
      end
   endtask

   // driver: set a lookup and push its expected colour for the monitor
   task automatic look(input int idx, input string tag);
      lut_index = 8'(idx);
      exp_q.push_back({mr[idx], mg[idx], mb[idx]});
      tag_q.push_back(tag);
      @(posedge clk); #2;
   endtask

   task automatic do_reset();
      @(posedge clk); #2;
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
      bus_addr = '0; bus_wdata = '0; redraw_clr = 1'b0; lut_index = '0;
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R6 reset state
      check(redraw_req === 1'b1, "R6 redraw after reset", {31'h0, redraw_req}, 1);
      look(0, "R6 entry 0 cleared");
      look(255, "R6 entry 255 cleared");
      look(77, "R6 entry 77 cleared");

      // R7 clear pulse
      @(posedge clk); #2 redraw_clr = 1'b1;
      @(posedge clk); #2 redraw_clr = 1'b0;
      check(redraw_req === 1'b0, "R7 clear", {31'h0, redraw_req}, 0);

      // R1 R2 byte fill of one entry, then R3 spill into the next
      bus_wr(5'h0, 0, 32'h0000_000A);
      bus_wr(5'h4, 0, 32'h0000_0012);
      check(redraw_req === 1'b1, "R7 set by data write", {31'h0, redraw_req}, 1);
      bus_wr(5'h4, 0, 32'h0000_0034);
      bus_wr(5'h4, 0, 32'h0000_0056);
      bus_wr(5'h4, 0, 32'h0000_0078);
      look(10, "R2 rgb order");
      look(11, "R3 advance after blue");

      // R3 wrap 255 -> 0
      bus_wr(5'h0, 0, 32'h0000_00FF);
      bus_wr(5'h4, 0, 32'h0000_00A1);
      bus_wr(5'h4, 0, 32'h0000_00A2);
      bus_wr(5'h4, 0, 32'h0000_00A3);
      bus_wr(5'h4, 0, 32'h0000_00B4);
      look(255, "R3 last entry");
      look(0, "R3 wrap to entry 0");

      // R1 pointer write mid-entry forces red
      bus_wr(5'h0, 0, 32'h0000_0014);
      bus_wr(5'h4, 0, 32'h0000_00C1);
      bus_wr(5'h4, 0, 32'h0000_00C2);
      bus_wr(5'h0, 1, 32'hFFFF_FF1E);
      bus_wr(5'h4, 0, 32'h0000_00C3);
      look(20, "R1 partial entry kept");
      look(30, "R1 slot back to red");

      // R4 word writes crossing entry boundaries
      bus_wr(5'h0, 0, 32'h0000_0028);
      bus_wr(5'h4, 1, 32'h1122_3344);
      bus_wr(5'h4, 1, 32'h5566_7788);
      bus_wr(5'h4, 1, 32'h99AA_BBCC);
      bus_wr(5'h4, 0, 32'h0000_00DD);
      look(40, "R4 word entry 40");
      look(41, "R4 word entry 41");
      look(42, "R4 word entry 42");
      look(43, "R4 word entry 43");
      look(44, "R4 byte after words");

      // R5 reads return zero and do not move the pointer
      @(posedge clk); #2;
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'h0;
      #1 check(bus_rdata === 32'h0, "R5 read pointer reg", bus_rdata, 0);
      bus_addr = 5'h4;
      #1 check(bus_rdata === 32'h0, "R5 read data reg", bus_rdata, 0);
      @(posedge clk); #2 bus_valid = 1'b0;
      bus_wr(5'h4, 0, 32'h0000_00EE);
      look(44, "R5 read left slot alone");

      // R9 other offsets and bus_valid low are ignored
      bus_wr(5'h8, 1, 32'h0102_0304);
      bus_wr(5'h1, 0, 32'h0000_0099);
      @(posedge clk); #2;
      bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 5'h4; bus_wdata = 32'h0000_0077;
      @(posedge clk); #2 bus_write = 1'b0;
      bus_wr(5'h4, 0, 32'h0000_00F0);
      look(44, "R9 stray writes ignored");
      look(45, "R9 next entry untouched");

      // R7 set wins over a same-cycle clear
      @(posedge clk); #2 redraw_clr = 1'b1;
      @(posedge clk); #2 redraw_clr = 1'b0;
      check(redraw_req === 1'b0, "R7 clear before collision", {31'h0, redraw_req}, 0);
      bus_wr(5'h4, 0, 32'h0000_0011, 1'b1);
      check(redraw_req === 1'b1, "R7 set wins over clear", {31'h0, redraw_req}, 1);

      // R8 lookup follows index combinationally: mixed traffic, sweep entries
      begin
         logic [15:0] lf;
         lf = 16'hACE1;
         for (int n = 0; n < 48; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0])
               2'd0:    bus_wr(5'h0, 0, {24'h0, 2'b00, lf[13:8]});
               2'd1:    bus_wr(5'h4, 1, {lf, ~lf});
               default: bus_wr(5'h4, 0, {24'h0, lf[15:8]});
            endcase
         end
      end
      for (int i = 0; i < 72; i++) look(i, "R8 sweep lookup");

      // R6 reset again clears a populated table
      do_reset();
      check(redraw_req === 1'b1, "R6 redraw after second reset", {31'h0, redraw_req}, 1);
      look(40, "R6 entry 40 cleared");
      look(10, "R6 entry 10 cleared");
      bus_wr(5'h4, 0, 32'h0000_0042);
      look(0, "R6 pointer and slot reset");

      @(posedge clk); #2;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule